// File: doc/BRIEF.md
# Fixed-point multiply-accumulate unit

This block multiplies two 32-bit fixed-point operands in a single clock and either keeps the plain product, adds it to a wide accumulator or subtracts it from that accumulator. The accumulator is 80 bits wide. That gives 16 guard bits above the 64-bit product, so long runs of accumulation stay exact. A single select treats both operands as signed or as unsigned. A clear control drops the old accumulator contents, so a new sum starts with the current product.

The accumulator is a register, and every operation takes effect at the clock edge on which it is presented. The value written on one edge is the base for the operation on the next edge, with no stall. The full accumulator is driven out unchanged. A 32-bit result is derived from it combinationally. That result is either the low word or the rounded high word (bits 63:32). When the accumulator does not fit the selected word, the result saturates and an overflow flag is raised.

Top module: `mac_unit`

## Requirements
- R1: While rst_ni is low, acc_o is zero, res_o is zero and ovf_o is low.
- R2: op_i = 2'b00 loads the accumulator with the product a_i*b_i. When sgn_i = 1, both operands are two's complement and the product is sign-extended to 80 bits. When sgn_i = 0, both operands are unsigned and the product is zero-extended.
- R3: op_i = 2'b01 adds the extended product to the accumulator, modulo 2^80.
- R4: op_i = 2'b10 subtracts the extended product from the accumulator, modulo 2^80.
- R5: op_i = 2'b11 with clr_i low leaves the accumulator unchanged.
- R6: With clr_i high, the old accumulator is replaced by zero before the operation. The add and subtract operations then give +product and -product, and op_i = 2'b11 gives zero.
- R7: Each operation is visible on acc_o right after the clock edge that takes it. The operation on the next edge uses that value, with no idle cycle.
- R8: With res_hi_i = 0, res_o is acc_o[31:0] when the accumulator fits 32 bits. In signed mode the range is -2^31..2^31-1. In unsigned mode acc_o is read as an unsigned 80-bit number and the range is 0..2^32-1. Otherwise res_o saturates: 32'h7FFFFFFF or 32'h80000000 in signed mode, 32'hFFFFFFFF in unsigned mode.
- R9: With res_hi_i = 1, 2^31 is added to the accumulator (signed or unsigned per sgn_i), and the sum is shifted right by 32. That value is res_o when it fits the 32-bit range of R8. Otherwise res_o saturates as in R8.
- R10: ovf_o is high exactly when res_o holds a saturated value forced by an out-of-range accumulator.
- R11: Accumulated sums above 2^64 are held exactly up to the 80-bit width. Subtracting the same products again returns the accumulator to its starting value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | 00 multiply, 01 accumulate, 10 subtract, 11 hold |
| sgn_i | input | 1 | 1 = signed operands and result, 0 = unsigned |
| clr_i | input | 1 | Replace old accumulator by zero for this operation |
| res_hi_i | input | 1 | 1 = rounded high word, 0 = low word |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| acc_o | output | 80 | Accumulator |
| res_o | output | 32 | Rounded and saturated 32-bit result |
| ovf_o | output | 1 | Result saturated |

## Verification
The accumulator is compared on every cycle against a 128-bit model. A wrong guard bit, a wrong sign extension or a dropped carry therefore shows on acc_o on the first cycle after the faulty operation. It also persists in every later sum until a multiply or a clear overwrites it. Faults in rounding or saturation sit in combinational logic after the register, so they show on res_o and ovf_o in the same cycle in which the accumulator enters the affected range. Long accumulate runs and full subtract-back runs push the sums beyond 2^64, so faults confined to the upper bits cannot stay hidden.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    OP_MUL  = 2'b00,
    OP_MAC  = 2'b01,
    OP_MSB  = 2'b10,
    OP_HOLD = 2'b11
  } mac_op_e;
endpackage

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W  = 32,
  parameter int ACC_W = 80
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic             sgn_i,
  output logic [ACC_W-1:0] prod_o
);
  localparam int XW = OP_W + 1;
  localparam int PW = 2 * XW;

  // one extra bit per operand lets a single signed multiplier cover both modes
  logic signed [XW-1:0] ax, bx;
  logic signed [PW-1:0] p;

  assign ax = {sgn_i & a_i[OP_W-1], a_i};
  assign bx = {sgn_i & b_i[OP_W-1], b_i};
  assign p  = ax * bx;

  generate
    if (ACC_W > PW) begin : g_ext
      assign prod_o = {{(ACC_W-PW){p[PW-1]}}, p};
    end else begin : g_trunc
      assign prod_o = p[ACC_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/mac_acc.sv
module mac_acc
  import mac_pkg::*;
#(
  parameter int ACC_W = 80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mac_op_e          op_i,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] prod_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q, base, acc_d;

  assign base = clr_i ? '0 : acc_q;

  always_comb begin
    unique case (op_i)
      OP_MUL:  acc_d = prod_i;
      OP_MAC:  acc_d = base + prod_i;
      OP_MSB:  acc_d = base - prod_i;
      default: acc_d = base;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  // R5
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_HOLD && !clr_i) |=> $stable(acc_q));
  // R2
  mul_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MUL) |=> acc_q == $past(prod_i));
  // R6
  clr_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MAC && clr_i) |=> acc_q == $past(prod_i));
  // R3
  mac_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MAC && !clr_i) |=> (acc_q - $past(acc_q)) == $past(prod_i));
  // R4
  msb_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_MSB && !clr_i) |=> ($past(acc_q) - acc_q) == $past(prod_i));
endmodule

// File: rtl/mac_result.sv
module mac_result #(
  parameter int OP_W  = 32,
  parameter int ACC_W = 80
) (
  input  logic [ACC_W-1:0] acc_i,
  input  logic             sgn_i,
  input  logic             res_hi_i,
  output logic [OP_W-1:0]  res_o,
  output logic             ovf_o
);
  localparam int SW = ACC_W + 1;
  localparam logic [SW-1:0] HALF = {{(SW-OP_W){1'b0}}, 1'b1, {(OP_W-1){1'b0}}};
  localparam logic [OP_W-1:0] S_MAX = {1'b0, {(OP_W-1){1'b1}}};
  localparam logic [OP_W-1:0] S_MIN = {1'b1, {(OP_W-1){1'b0}}};

  logic signed [SW-1:0] ext, rnd, sh;
  logic fits, neg;

  // one bit wider than the accumulator so the rounding add cannot wrap
  assign ext = {sgn_i & acc_i[ACC_W-1], acc_i};
  assign rnd = res_hi_i ? (ext + HALF) : ext;
  assign sh  = res_hi_i ? (rnd >>> OP_W) : rnd;
  assign neg = sh[SW-1];

  always_comb begin
    if (sgn_i) fits = (sh[SW-1:OP_W-1] == '0) || (sh[SW-1:OP_W-1] == '1);
    else       fits = (sh[SW-1:OP_W] == '0);
  end

  always_comb begin
    if (fits)       res_o = sh[OP_W-1:0];
    else if (!sgn_i) res_o = '1;
    else            res_o = neg ? S_MIN : S_MAX;
  end

  assign ovf_o = !fits;
endmodule

// File: rtl/mac_unit.sv
module mac_unit
  import mac_pkg::*;
#(
  parameter int OP_W    = 32,
  parameter int GUARD_W = 16,
  localparam int ACC_W  = 2 * OP_W + GUARD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       op_i,
  input  logic             sgn_i,
  input  logic             clr_i,
  input  logic             res_hi_i,
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  output logic [ACC_W-1:0] acc_o,
  output logic [OP_W-1:0]  res_o,
  output logic             ovf_o
);
  localparam logic [OP_W-1:0] S_MAX = {1'b0, {(OP_W-1){1'b1}}};
  localparam logic [OP_W-1:0] S_MIN = {1'b1, {(OP_W-1){1'b0}}};

  logic [ACC_W-1:0] prod;
  mac_op_e          op;

  assign op = mac_op_e'(op_i);

  mac_mult #(.OP_W(OP_W), .ACC_W(ACC_W)) u_mult (
    .a_i(a_i), .b_i(b_i), .sgn_i(sgn_i), .prod_o(prod)
  );

  mac_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op), .clr_i(clr_i),
    .prod_i(prod), .acc_o(acc_o)
  );

  mac_result #(.OP_W(OP_W), .ACC_W(ACC_W)) u_res (
    .acc_i(acc_o), .sgn_i(sgn_i), .res_hi_i(res_hi_i),
    .res_o(res_o), .ovf_o(ovf_o)
  );

  // R10
  sat_value_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> (sgn_i ? (res_o == S_MAX || res_o == S_MIN) : (res_o == '1)));
  // R8
  low_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_hi_i && !ovf_o) |-> res_o == acc_o[OP_W-1:0]);
  // R8
  low_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!res_hi_i && !sgn_i && acc_o[ACC_W-1:OP_W] == '0) |-> !ovf_o);
  // R9
  hi_small_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_hi_i && !sgn_i && acc_o[ACC_W-1:2*OP_W] == '0 && !(&acc_o[2*OP_W-1:OP_W-1]))
      |-> (!ovf_o && res_o == acc_o[2*OP_W-1:OP_W] + OP_W'(acc_o[OP_W-1])));
endmodule

// File: tb/mac_unit_bench.sv
module mac_unit_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  op_i = 2'b11;
  logic        sgn_i = 1'b0, clr_i = 1'b0, res_hi_i = 1'b0;
  logic [31:0] a_i = '0, b_i = '0;
  logic [79:0] acc_o;
  logic [31:0] res_o;
  logic        ovf_o;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [79:0] model = '0;

  always #2 clk_i = ~clk_i;

  mac_unit u_mac_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .op_i(op_i), .sgn_i(sgn_i), .clr_i(clr_i),
    .res_hi_i(res_hi_i), .a_i(a_i), .b_i(b_i),
    .acc_o(acc_o), .res_o(res_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tg, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  function automatic void ref_res(input logic [79:0] acc, input logic sg, input logic hi,
                                  output logic [31:0] r, output logic o);
    logic signed [127:0] v;
    v = sg ? {{48{acc[79]}}, acc} : {48'b0, acc};
    if (hi) v = (v + 128'sd2147483648) >>> 32;
    o = 1'b0;
    r = v[31:0];
    if (sg) begin
      if (v > 128'sd2147483647) begin r = 32'h7FFFFFFF; o = 1'b1; end
      else if (v < -128'sd2147483648) begin r = 32'h80000000; o = 1'b1; end
    end else if (v > 128'sd4294967295) begin
      r = 32'hFFFFFFFF; o = 1'b1;
    end
  endfunction

  task automatic step(input logic [1:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic sg, input logic cl, input logic hi, input string tg);
    logic signed [127:0] p;
    logic [79:0] base;
    logic [31:0] er;
    logic eo;
    string t;
    @(negedge clk_i);
    op_i = op; a_i = a; b_i = b; sgn_i = sg; clr_i = cl; res_hi_i = hi;
    p = sg ? ($signed({{96{a[31]}}, a}) * $signed({{96{b[31]}}, b}))
           : ($signed({96'b0, a}) * $signed({96'b0, b}));
    base = cl ? 80'd0 : model;
    case (op)
      2'b00: model = p[79:0];
      2'b01: model = base + p[79:0];
      2'b10: model = base - p[79:0];
      default: model = base;
    endcase
    @(posedge clk_i);
    #1;
    if (tg != "") t = tg;
    else if (cl) t = "R6";
    else case (op)
      2'b00: t = "R2";
      2'b01: t = "R3";
      2'b10: t = "R4";
      default: t = "R5";
    endcase
    chk({t, " acc"}, {48'b0, acc_o}, {48'b0, model});
    ref_res(model, sg, hi, er, eo);
    chk(hi ? "R9 res" : "R8 res", {96'b0, res_o}, {96'b0, er});
    chk("R10 ovf", {127'b0, ovf_o}, {127'b0, eo});
  endtask

  initial begin
    #700000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] corner [8];
    logic [31:0] lfsr;
    corner[0] = 32'h0;        corner[1] = 32'h1;
    corner[2] = 32'hFFFFFFFF; corner[3] = 32'h7FFFFFFF;
    corner[4] = 32'h80000000; corner[5] = 32'h00010000;
    corner[6] = 32'h12345678; corner[7] = 32'hC0000001;

    // R1 reset state
    #10;
    chk("R1 acc", {48'b0, acc_o}, 128'd0);
    chk("R1 res", {96'b0, res_o}, 128'd0);
    chk("R1 ovf", {127'b0, ovf_o}, 128'd0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // corner sweep across all ops, modes and clear
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          for (int k = 0; k < 4; k++)
            step(2'(k), corner[i], corner[j], 1'(s), ((i + j + k) % 5) == 0,
                 1'((i + k) & 1), "");

    // R11 signed growth past 2^64, then back to zero
    step(2'b00, 32'h80000000, 32'h80000000, 1'b1, 1'b0, 1'b1, "R2");
    for (int n = 0; n < 299; n++)
      step(2'b01, 32'h80000000, 32'h80000000, 1'b1, 1'b0, n[0], "R11");
    for (int n = 0; n < 300; n++)
      step(2'b10, 32'h80000000, 32'h80000000, 1'b1, 1'b0, n[0], "R11");
    chk("R11 zero", {48'b0, acc_o}, 128'd0);

    // R11 unsigned growth to about 2^75, then back down
    step(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b1, 1'b0, "R6");
    for (int n = 0; n < 1999; n++)
      step(2'b01, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, n[1], "R11");
    for (int n = 0; n < 2000; n++)
      step(2'b10, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b0, 1'b0, n[1], "R11");
    chk("R11 zero", {48'b0, acc_o}, 128'd0);

    // signed negative growth
    for (int n = 0; n < 200; n++)
      step(2'b10, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1, 1'b0, n[0], "R11");

    // R7 back-to-back mixed stream
    lfsr = 32'hACE1_2345;
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] ra, rb;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      ra = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rb = lfsr >> lfsr[4:0];
      step(lfsr[9:8], ra, rb, lfsr[12], lfsr[15:13] == 3'b000, lfsr[17], "R7");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule